// File: doc/BRIEF.md
# Two-Word Control Port Decoder

This block sits behind the 16-bit control port of a display controller. Each accepted word is one of two things. It is either a write to one of the internal 8-bit configuration registers, or one half of a setup that loads a 16-bit access address and a 6-bit access code. The memory behind the data port then uses that address and code.

A setup takes two words, so the block keeps a pending flag that records whether the first half has arrived. While the flag is set, the next word always completes the setup, even if it looks like a register write. Any data-port access or status read drops the flag, which abandons a half-finished setup.

The block also forms the status word from the FIFO empty and full inputs. From the current code it tells the data path whether a read must return zero and which memory a read targets.

Control words arrive over a valid/ready handshake. The block never applies back-pressure: `ctl_ready` is high whenever reset is not asserted, so a word is taken in every cycle in which `ctl_valid` is high. All other pins are plain single-cycle strobes or levels.

Top module: `ctl_port_decoder`

## Requirements
- R1: With pending clear, an accepted word whose bits 15:14 are 2'b10 is a register write. One cycle later `reg_wr_en` pulses for one cycle, carrying index = word bits 12:8 and data = word bits 7:0. The register file holds that data from then on. The address, the code and the pending flag are unchanged.
- R2: A register write whose index is at or above NREGS (default 24) is ignored. No strobe is raised and no register changes.
- R3: With pending clear, an accepted word whose bits 15:14 are not 2'b10 sets pending. It loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14. The other address and code bits are kept.
- R4: With pending set, an accepted word loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 5:2, then clears pending. This holds even when its bits 15:14 are 2'b10, and in that case no register write occurs.
- R5: A cycle with `data_wr`, `data_rd` or `stat_rd` high and no accepted control word clears pending by the next cycle. The address and code are left unchanged.
- R6: When a control word is accepted in the same cycle as a data-port access or status read, the control word's effect wins. A first half leaves pending set, and a register write still happens.
- R7: `stat_word` is 16'h3400 with bit 9 set while `fifo_empty` is high and bit 8 set while `fifo_full` is high.
- R8: `rd_zero` is high exactly when code bit 0 is clear. A data-port read must then return zero.
- R9: `rd_tgt` decodes code bits 3:0 as follows: 4'b0000 gives 1 (VRAM), 4'b1000 gives 2 (colour RAM), 4'b0100 gives 3 (vertical scroll RAM), and any other value gives 0.
- R10: A synchronous active-low reset clears pending, the address, the code, the write strobe and all NREGS registers to zero.
- R11: `ctl_ready` is high whenever reset is not asserted. A word is consumed in any cycle with `ctl_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_valid | input | 1 | Control word offered |
| ctl_ready | output | 1 | Control word accepted (no back-pressure) |
| ctl_word | input | 16 | Control word |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status read strobe |
| fifo_empty | input | 1 | Write FIFO is empty |
| fifo_full | input | 1 | Write FIFO is full |
| reg_rd_idx | input | 5 | Register readback index |
| reg_rd_val | output | 8 | Register readback data (zero when out of range) |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_idx | output | 5 | Register write index |
| reg_wr_val | output | 8 | Register write data |
| pending | output | 1 | First half of a setup received |
| acc_addr | output | 16 | Access address |
| acc_code | output | 6 | Access code |
| stat_word | output | 16 | Status word |
| rd_zero | output | 1 | Data-port read must return zero |
| rd_tgt | output | 2 | Read target: 0 none, 1 VRAM, 2 colour RAM, 3 vertical scroll RAM |

## Verification
Four kinds of rule are checked in every cycle, with no reliance on a particular scenario:

- a first half always leaves pending set;
- a second half always clears it;
- an access with no control word clears it;
- no register strobe follows a word taken while pending, and no strobe carries an out-of-range index.

The exact placement of the word's bits into the address, the code, the register index and the register data can only be shown by the bench's scenarios. The same is true of the contents of the register file, the ignored out-of-range writes, and the status and read-target decodes.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  typedef enum logic [1:0] {
    W_IDLE   = 2'd0,
    W_REGWR  = 2'd1,
    W_FIRST  = 2'd2,
    W_SECOND = 2'd3
  } wkind_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } rd_tgt_e;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned LO_ADR_W = 14;

endpackage

// File: rtl/ctl_word_decode.sv
module ctl_word_decode
  import ctl_port_pkg::*;
#(
  parameter int unsigned NREGS = 24
) (
  input  logic              valid,
  input  logic              pending,
  input  logic [WORD_W-1:0] word,
  output wkind_e            kind,
  output logic [IDX_W-1:0]  idx,
  output logic [REG_W-1:0]  val
);

  logic is_reg_pattern;
  logic idx_ok;

  assign is_reg_pattern = (word[15:14] == 2'b10);
  assign idx            = word[12:8];
  assign val            = word[REG_W-1:0];
  assign idx_ok         = ({27'd0, idx} < NREGS);

  always_comb begin
    kind = W_IDLE;
    if (valid) begin
      if (pending)             kind = W_SECOND;
      else if (!is_reg_pattern) kind = W_FIRST;
      else if (idx_ok)          kind = W_REGWR;
      else                      kind = W_IDLE;
    end
  end

endmodule

// File: rtl/ctl_setup_latch.sv
module ctl_setup_latch
  import ctl_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wkind_e            kind,
  input  logic [WORD_W-1:0] word,
  input  logic              clr_req,
  output logic              pending,
  output logic [WORD_W-1:0] addr,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      addr    <= '0;
      code    <= '0;
    end else begin
      unique case (kind)
        W_FIRST: begin
          pending                <= 1'b1;
          addr[LO_ADR_W-1:0]     <= word[LO_ADR_W-1:0];
          code[1:0]              <= word[15:14];
        end
        W_SECOND: begin
          pending                <= 1'b0;
          addr[WORD_W-1:LO_ADR_W] <= word[1:0];
          code[5:2]              <= word[5:2];
        end
        default: begin
          if (clr_req) pending <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import ctl_port_pkg::*;
#(
  parameter int unsigned NREGS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [REG_W-1:0] wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [REG_W-1:0] rval,
  output logic             wr_en_q,
  output logic [IDX_W-1:0] wr_idx_q,
  output logic [REG_W-1:0] wr_val_q
);

  logic [REG_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  regs[g] <= '0;
      else if (we && (widx == IDX_W'(g)))          regs[g] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
      wr_val_q <= '0;
    end else begin
      wr_en_q  <= we;
      if (we) begin
        wr_idx_q <= widx;
        wr_val_q <= wval;
      end
    end
  end

  always_comb begin
    rval = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (ridx == IDX_W'(i)) rval = regs[i];
    end
  end

endmodule

// File: rtl/ctl_status.sv
module ctl_status
  import ctl_port_pkg::*;
(
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] stat_word,
  output logic              rd_zero,
  output rd_tgt_e           rd_tgt
);

  localparam logic [WORD_W-1:0] STAT_BASE = 16'h3400;

  always_comb begin
    stat_word    = STAT_BASE;
    stat_word[9] = fifo_empty;
    stat_word[8] = fifo_full;
  end

  assign rd_zero = ~code[0];

  always_comb begin
    unique case (code[3:0])
      4'b0000: rd_tgt = TGT_VRAM;
      4'b1000: rd_tgt = TGT_CRAM;
      4'b0100: rd_tgt = TGT_VSRAM;
      default: rd_tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/ctl_port_decoder.sv
module ctl_port_decoder
  import ctl_port_pkg::*;
#(
  parameter int unsigned NREGS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_valid,
  output logic        ctl_ready,
  input  logic [15:0] ctl_word,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic        stat_rd,
  input  logic        fifo_empty,
  input  logic        fifo_full,
  input  logic [4:0]  reg_rd_idx,
  output logic [7:0]  reg_rd_val,
  output logic        reg_wr_en,
  output logic [4:0]  reg_wr_idx,
  output logic [7:0]  reg_wr_val,
  output logic        pending,
  output logic [15:0] acc_addr,
  output logic [5:0]  acc_code,
  output logic [15:0] stat_word,
  output logic        rd_zero,
  output logic [1:0]  rd_tgt
);

  wkind_e           kind;
  logic [IDX_W-1:0] dec_idx;
  logic [REG_W-1:0] dec_val;
  logic             accept;
  logic             clr_req;
  rd_tgt_e          tgt;

  assign ctl_ready = rst_n;
  assign accept    = ctl_valid & ctl_ready;
  assign clr_req   = data_wr | data_rd | stat_rd;

  ctl_word_decode #(.NREGS(NREGS)) u_dec (
    .valid   (accept),
    .pending (pending),
    .word    (ctl_word),
    .kind    (kind),
    .idx     (dec_idx),
    .val     (dec_val)
  );

  ctl_setup_latch u_setup (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .word    (ctl_word),
    .clr_req (clr_req),
    .pending (pending),
    .addr    (acc_addr),
    .code    (acc_code)
  );

  ctl_reg_file #(.NREGS(NREGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (kind == W_REGWR),
    .widx     (dec_idx),
    .wval     (dec_val),
    .ridx     (reg_rd_idx),
    .rval     (reg_rd_val),
    .wr_en_q  (reg_wr_en),
    .wr_idx_q (reg_wr_idx),
    .wr_val_q (reg_wr_val)
  );

  ctl_status u_stat (
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .code       (acc_code),
    .stat_word  (stat_word),
    .rd_zero    (rd_zero),
    .rd_tgt     (tgt)
  );

  assign rd_tgt = tgt;

endmodule

// File: rtl/ctl_port_decoder_chk.sv
module ctl_port_decoder_chk #(
  parameter int unsigned NREGS = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_valid,
  input logic [15:0] ctl_word,
  input logic        data_wr,
  input logic        data_rd,
  input logic        stat_rd,
  input logic        reg_wr_en,
  input logic [4:0]  reg_wr_idx,
  input logic        pending,
  input logic [15:0] acc_addr,
  input logic [5:0]  acc_code
);

  p_first_half_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !pending && ctl_word[15:14] != 2'b10) |=> pending);

  p_second_half_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && pending) |=> !pending);

  p_no_regwr_when_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && pending) |=> !reg_wr_en);

  p_access_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_valid && (data_wr || data_rd || stat_rd)) |=> !pending);

  p_setup_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |=> ($stable(acc_addr) && $stable(acc_code)));

  p_index_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ({27'd0, reg_wr_idx} < NREGS));

  p_strobe_needs_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |=> !reg_wr_en);

endmodule

bind ctl_port_decoder ctl_port_decoder_chk #(.NREGS(NREGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_valid  (ctl_valid),
  .ctl_word   (ctl_word),
  .data_wr    (data_wr),
  .data_rd    (data_rd),
  .stat_rd    (stat_rd),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_idx (reg_wr_idx),
  .pending    (pending),
  .acc_addr   (acc_addr),
  .acc_code   (acc_code)
);

// File: tb/ctl_port_decoder_test.sv
`timescale 1ns/1ps
module ctl_port_decoder_test;

  localparam int unsigned NREGS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic        ctl_ready;
  logic [15:0] ctl_word = '0;
  logic        data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic        fifo_empty = 1'b1, fifo_full = 1'b0;
  logic [4:0]  reg_rd_idx = '0;
  logic [7:0]  reg_rd_val;
  logic        reg_wr_en;
  logic [4:0]  reg_wr_idx;
  logic [7:0]  reg_wr_val;
  logic        pending;
  logic [15:0] acc_addr;
  logic [5:0]  acc_code;
  logic [15:0] stat_word;
  logic        rd_zero;
  logic [1:0]  rd_tgt;

  always #2.5 clk = ~clk;

  ctl_port_decoder #(.NREGS(NREGS)) uut (.*);

  typedef struct {
    logic        pend;
    logic [15:0] addr;
    logic [5:0]  code;
    logic        wen;
    logic [4:0]  widx;
    logic [7:0]  wval;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        m_pend = 1'b0;
  logic [15:0] m_addr = '0;
  logic [5:0]  m_code = '0;
  logic [7:0]  m_regs [32];

  task automatic cyc(input logic v, input logic [15:0] w, input logic dw,
                     input logic dr, input logic sr, input string tag);
    exp_t e;
    @(negedge clk);
    ctl_valid = v; ctl_word = w; data_wr = dw; data_rd = dr; stat_rd = sr;
    e.wen = 1'b0; e.widx = '0; e.wval = '0;
    if (v) begin
      if (m_pend) begin
        m_addr[15:14] = w[1:0];
        m_code[5:2]   = w[5:2];
        m_pend        = 1'b0;
      end else if (w[15:14] == 2'b10) begin
        if (w[12:8] < NREGS) begin
          e.wen = 1'b1; e.widx = w[12:8]; e.wval = w[7:0];
          m_regs[w[12:8]] = w[7:0];
        end
      end else begin
        m_pend        = 1'b1;
        m_addr[13:0]  = w[13:0];
        m_code[1:0]   = w[15:14];
      end
    end else if (dw || dr || sr) begin
      m_pend = 1'b0;
    end
    e.pend = m_pend; e.addr = m_addr; e.code = m_code;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (pending !== e.pend || acc_addr !== e.addr || acc_code !== e.code ||
            reg_wr_en !== e.wen ||
            (e.wen && (reg_wr_idx !== e.widx || reg_wr_val !== e.wval))) begin
          n_bad++;
          $display("FAIL %s: got pend=%0b addr=%h code=%h wen=%0b idx=%0d val=%h exp pend=%0b addr=%h code=%h wen=%0b idx=%0d val=%h",
                   t, pending, acc_addr, acc_code, reg_wr_en, reg_wr_idx, reg_wr_val,
                   e.pend, e.addr, e.code, e.wen, e.widx, e.wval);
        end
      end
    end
  end

  task automatic chk_reg(input logic [4:0] idx, input logic [7:0] expv, input string tag);
    @(negedge clk);
    reg_rd_idx = idx;
    #1;
    n_cmp++;
    if (reg_rd_val !== expv) begin
      n_bad++;
      $display("FAIL %s: reg[%0d] got %h exp %h", tag, idx, reg_rd_val, expv);
    end
  endtask

  task automatic chk_stat(input logic e, input logic f, input logic [15:0] expv, input string tag);
    @(negedge clk);
    fifo_empty = e; fifo_full = f;
    #1;
    n_cmp++;
    if (stat_word !== expv) begin
      n_bad++;
      $display("FAIL %s: status got %h exp %h", tag, stat_word, expv);
    end
  endtask

  task automatic chk_rd(input logic ez, input logic [1:0] et, input string tag);
    @(negedge clk);
    #1;
    n_cmp++;
    if (rd_zero !== ez || rd_tgt !== et) begin
      n_bad++;
      $display("FAIL %s: rd_zero=%0b tgt=%0d exp rd_zero=%0b tgt=%0d", tag, rd_zero, rd_tgt, ez, et);
    end
  endtask

  task automatic set_code(input logic [5:0] c);
    cyc(1'b1, {c[1:0], 14'h0}, 1'b0, 1'b0, 1'b0, "R9 first half");
    cyc(1'b1, {10'h0, c[5:2], 2'b00}, 1'b0, 1'b0, 1'b0, "R9 second half");
    idle(1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    n_cmp++;
    if (pending !== 1'b0 || acc_addr !== 16'h0 || acc_code !== 6'h0 || reg_wr_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: pend=%0b addr=%h code=%h wen=%0b exp all zero", pending, acc_addr, acc_code, reg_wr_en);
    end
    // R11: never back-pressures
    n_cmp++;
    if (ctl_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: ctl_ready got %0b exp 1", ctl_ready);
    end
    chk_reg(5'd0, 8'h00, "R10 reg0");
    chk_reg(5'd23, 8'h00, "R10 reg23");

    // R1: register writes
    cyc(1'b1, 16'h8512, 1'b0, 1'b0, 1'b0, "R1 idx5");
    cyc(1'b1, 16'h97AB, 1'b0, 1'b0, 1'b0, "R1 idx23");
    // R2: out-of-range index ignored
    cyc(1'b1, 16'h98CD, 1'b0, 1'b0, 1'b0, "R2 idx24");
    cyc(1'b1, 16'h9FEE, 1'b0, 1'b0, 1'b0, "R2 idx31");
    idle(1);
    chk_reg(5'd5, 8'h12, "R1 readback5");
    chk_reg(5'd23, 8'hAB, "R1 readback23");
    chk_reg(5'd0, 8'h00, "R2 reg0 untouched");

    // R3 / R4: two-word setup
    cyc(1'b1, 16'h4ABC, 1'b0, 1'b0, 1'b0, "R3 first half");
    cyc(1'b1, 16'h003E, 1'b0, 1'b0, 1'b0, "R4 second half");
    idle(1);
    // R4: second half looking like a register write
    cyc(1'b1, 16'hC000, 1'b0, 1'b0, 1'b0, "R3 first half top11");
    cyc(1'b1, 16'h8003, 1'b0, 1'b0, 1'b0, "R4 second half top10");
    idle(1);
    chk_reg(5'd0, 8'h00, "R4 no register write");

    // R5: accesses abandon a half-finished setup
    cyc(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, "R3 first half");
    cyc(1'b0, 16'h0,    1'b1, 1'b0, 1'b0, "R5 data write clears");
    cyc(1'b1, 16'h2222, 1'b0, 1'b0, 1'b0, "R3 first half");
    cyc(1'b0, 16'h0,    1'b0, 1'b1, 1'b0, "R5 data read clears");
    cyc(1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0, "R3 first half");
    cyc(1'b0, 16'h0,    1'b0, 1'b0, 1'b1, "R5 status read clears");
    // after a clear, a 10 word is a register write again
    cyc(1'b1, 16'h8177, 1'b0, 1'b0, 1'b0, "R1 idx1 after clear");

    // R6: control word wins over same-cycle access
    cyc(1'b1, 16'h3333, 1'b1, 1'b0, 1'b0, "R6 first half with data write");
    cyc(1'b1, 16'h0004, 1'b0, 1'b1, 1'b0, "R6 second half with data read");
    cyc(1'b1, 16'h8255, 1'b0, 1'b0, 1'b1, "R6 reg write with status read");
    idle(2);
    chk_reg(5'd2, 8'h55, "R6 readback2");
    chk_reg(5'd1, 8'h77, "R1 readback1");

    // R7: status word
    chk_stat(1'b0, 1'b0, 16'h3400, "R7 neither");
    chk_stat(1'b1, 1'b0, 16'h3600, "R7 empty");
    chk_stat(1'b0, 1'b1, 16'h3500, "R7 full");
    chk_stat(1'b1, 1'b1, 16'h3700, "R7 both");

    // R8 / R9: read gating and target decode
    set_code(6'h00);
    chk_rd(1'b1, 2'd1, "R9 vram code0 R8");
    set_code(6'h08);
    chk_rd(1'b1, 2'd2, "R9 cram code8");
    set_code(6'h04);
    chk_rd(1'b1, 2'd3, "R9 vsram code4");
    set_code(6'h01);
    chk_rd(1'b0, 2'd0, "R8 code1 not zeroed");
    set_code(6'h21);
    chk_rd(1'b0, 2'd0, "R8 code21");

    idle(2);
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule